// File: doc/BRIEF.md
# Sign-Magnitude Min-Sum Node Processor

This block is the arithmetic core of one processing element in a semi-parallel successive-cancellation polar decoder. It is purely combinational. It takes two log-likelihood ratios in sign-magnitude form and produces one result per evaluation. That result is either the min-sum check-node value (f) or the partial-sum-controlled variable-node value (g), and a select bit chooses between them.

The g magnitude is not formed by a serial chain of compare, negate and add. The block computes three candidates side by side: the sum, and the difference in each direction. It then picks one using the partial sum and the two input signs. A single magnitude comparison feeds both f and g.

In the paired variant, g is evaluated for both possible partial-sum values at the same time as f. The hard decision taken from f then picks the right g, so the two bits of the last stage come out of one pass. Each decision is forced to 0 when its frozen flag is set.

Top module: `spm_pe`

## Requirements
- R1: When `sel_g` is 0, `llr_out` magnitude (bits Q-2..0) equals the smaller of the two input magnitudes. Its sign (bit Q-1, where 1 means negative) equals the XOR of the input signs.
- R2: When `sel_g` is 1, `llr_out` equals the sign-magnitude encoding of (-1)^psum·a + b. When the effective signs differ, the sign is psum XOR sign(a) if |a| > |b|, and sign(b) otherwise.
- R3: A g result whose true magnitude exceeds 2^(Q-1)-1 is clamped to 2^(Q-1)-1, and the sign of the sum is kept.
- R4: Any result with zero magnitude has sign bit 0, so the code for negative zero never appears on `llr_out`.
- R5: `sel_g` picks f (0) or g (1) for `llr_out` over the same inputs.
- R6: `bit0` is 0 when `frz0` is 1. Otherwise it equals the sign bit of the f result.
- R7: `bit1` is 0 when `frz1` is 1. Otherwise it equals the sign bit of the g result evaluated with a partial sum equal to `bit0`, including a `bit0` forced by `frz0`.
- R8: In f mode, `psum` has no effect on `llr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | Q | First LLR, sign in bit Q-1, magnitude below |
| b | input | Q | Second LLR, same encoding |
| psum | input | 1 | Partial-sum bit used by g |
| sel_g | input | 1 | 0 selects f, 1 selects g |
| frz0 | input | 1 | Frozen flag for the first stage-0 bit |
| frz1 | input | 1 | Frozen flag for the second stage-0 bit |
| llr_out | output | Q | Selected result LLR |
| bit0 | output | 1 | First decided bit (paired variant) |
| bit1 | output | 1 | Second decided bit (paired variant) |

## Verification
At Q=5, every combination of the two LLRs, the partial sum, the select bit and both frozen flags is applied and compared with an integer reference. This run separates the sum, difference and saturation cases of g and both orders of magnitude. It also covers the equal-magnitude and signed-zero inputs that must yield positive zero. The frozen-flag combinations show whether the second decision follows the first decision after forcing, or the raw f sign. A seeded random pass then repeats the comparison on mixed inputs.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic {
        OP_F = 1'b0,
        OP_G = 1'b1
    } pe_op_e;

    function automatic logic decide_bit(input logic sgn, input logic frozen);
        return frozen ? 1'b0 : sgn;
    endfunction

endpackage

// File: rtl/spm_cmp.sv
module spm_cmp #(
    parameter int M = 4
) (
    input  logic [M-1:0] ma,
    input  logic [M-1:0] mb,
    output logic         a_gt_b,
    output logic [M-1:0] mag_min
);
    always_comb begin
        a_gt_b  = (ma > mb);
        mag_min = a_gt_b ? mb : ma;
        // R1: the minimum never exceeds either operand
        a_r1_min_bound: assert (mag_min <= ma && mag_min <= mb)
            else $error("min above operand");
    end
endmodule

// File: rtl/spm_fnode.sv
module spm_fnode #(
    parameter int M = 4
) (
    input  logic         sa,
    input  logic         sb,
    input  logic [M-1:0] mag_min,
    output logic         f_sgn,
    output logic [M-1:0] f_mag
);
    always_comb begin
        f_mag = mag_min;
        f_sgn = (sa ^ sb) && (mag_min != '0);
        a_r4_f_zero_pos: assert (!(f_mag == '0 && f_sgn))
            else $error("f negative zero");
    end
endmodule

// File: rtl/spm_gcand.sv
module spm_gcand #(
    parameter int M = 4
) (
    input  logic [M-1:0] ma,
    input  logic [M-1:0] mb,
    output logic [M-1:0] d_ab,
    output logic [M-1:0] d_ba,
    output logic [M-1:0] sum_sat
);
    localparam logic [M-1:0] MAG_MAX = '1;
    logic [M:0] sum_w;

    always_comb begin
        d_ab    = ma - mb;
        d_ba    = mb - ma;
        sum_w   = {1'b0, ma} + {1'b0, mb};
        sum_sat = sum_w[M] ? MAG_MAX : sum_w[M-1:0];
        a_r3_no_overflow: assert (sum_sat >= ma && sum_sat >= mb)
            else $error("sum wrapped");
    end
endmodule

// File: rtl/spm_gpick.sv
module spm_gpick #(
    parameter int M = 4
) (
    input  logic         s,
    input  logic         sa,
    input  logic         sb,
    input  logic         a_gt_b,
    input  logic [M-1:0] d_ab,
    input  logic [M-1:0] d_ba,
    input  logic [M-1:0] sum_sat,
    output logic         g_sgn,
    output logic [M-1:0] g_mag
);
    logic eff_sa;
    logic raw_sgn;

    always_comb begin
        eff_sa = s ^ sa;
        if (eff_sa == sb) begin
            g_mag   = sum_sat;
            raw_sgn = sb;
        end else if (a_gt_b) begin
            g_mag   = d_ab;
            raw_sgn = eff_sa;
        end else begin
            g_mag   = d_ba;
            raw_sgn = sb;
        end
        g_sgn = raw_sgn && (g_mag != '0);
        a_r4_g_zero_pos: assert (!(g_mag == '0 && g_sgn))
            else $error("g negative zero");
    end
endmodule

// File: rtl/spm_pe.sv
module spm_pe #(
    parameter int Q    = 5,
    parameter bit DUAL = 1'b1
) (
    input  logic [Q-1:0] a,
    input  logic [Q-1:0] b,
    input  logic         psum,
    input  logic         sel_g,
    input  logic         frz0,
    input  logic         frz1,
    output logic [Q-1:0] llr_out,
    output logic         bit0,
    output logic         bit1
);
    import spm_pkg::*;

    localparam int M = Q - 1;

    typedef struct packed {
        logic [Q-1:0] llr;
        logic         b0;
        logic         b1;
    } pe_out_t;

    logic         a_gt_b;
    logic [M-1:0] mag_min;
    logic         f_sgn;
    logic [M-1:0] f_mag;
    logic [M-1:0] d_ab, d_ba, sum_sat;
    logic         g_sgn [2];
    logic [M-1:0] g_mag [2];
    pe_out_t      out_d;
    pe_op_e       op;

    spm_cmp #(.M(M)) u_cmp (
        .ma(a[M-1:0]), .mb(b[M-1:0]), .a_gt_b(a_gt_b), .mag_min(mag_min)
    );

    spm_fnode #(.M(M)) u_f (
        .sa(a[M]), .sb(b[M]), .mag_min(mag_min), .f_sgn(f_sgn), .f_mag(f_mag)
    );

    spm_gcand #(.M(M)) u_cand (
        .ma(a[M-1:0]), .mb(b[M-1:0]), .d_ab(d_ab), .d_ba(d_ba), .sum_sat(sum_sat)
    );

    // one selector per possible partial-sum value, evaluated in parallel
    for (genvar gi = 0; gi < 2; gi++) begin : g_spec
        spm_gpick #(.M(M)) u_pick (
            .s(1'(gi)), .sa(a[M]), .sb(b[M]), .a_gt_b(a_gt_b),
            .d_ab(d_ab), .d_ba(d_ba), .sum_sat(sum_sat),
            .g_sgn(g_sgn[gi]), .g_mag(g_mag[gi])
        );
    end

    always_comb begin
        op = pe_op_e'(sel_g);
        if (op == OP_G) begin
            out_d.llr = psum ? {g_sgn[1], g_mag[1]} : {g_sgn[0], g_mag[0]};
        end else begin
            out_d.llr = {f_sgn, f_mag};
        end
        if (DUAL) begin
            out_d.b0 = decide_bit(f_sgn, frz0);
            out_d.b1 = decide_bit(out_d.b0 ? g_sgn[1] : g_sgn[0], frz1);
        end else begin
            out_d.b0 = 1'b0;
            out_d.b1 = 1'b0;
        end
    end

    assign llr_out = out_d.llr;
    assign bit0    = out_d.b0;
    assign bit1    = out_d.b1;

    always_comb begin
        a_r6_frozen_first: assert (!(frz0 && out_d.b0)) else $error("bit0 frozen");
        a_r7_frozen_second: assert (!(frz1 && out_d.b1)) else $error("bit1 frozen");
    end
endmodule

// File: tb/tb_spm_pe.sv
module tb_spm_pe;
    localparam int Q     = 5;
    localparam int M     = Q - 1;
    localparam int MAXM  = (1 << M) - 1;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [Q-1:0] a, b, llr_out;
    logic psum, sel_g, frz0, frz1, bit0, bit1;
    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spm_pe #(.Q(Q), .DUAL(1'b1)) dut (
        .a(a), .b(b), .psum(psum), .sel_g(sel_g), .frz0(frz0), .frz1(frz1),
        .llr_out(llr_out), .bit0(bit0), .bit1(bit1)
    );

    function automatic int to_int(input logic [Q-1:0] v);
        int m = int'(v[M-1:0]);
        return v[M] ? -m : m;
    endfunction

    function automatic logic [Q-1:0] to_sm(input int r);
        int c = r;
        if (c > MAXM) c = MAXM;
        if (c < -MAXM) c = -MAXM;
        return (c < 0) ? {1'b1, M'(-c)} : {1'b0, M'(c)};
    endfunction

    function automatic logic [Q-1:0] ref_f(input logic [Q-1:0] x, input logic [Q-1:0] y);
        int mx = int'(x[M-1:0]);
        int my = int'(y[M-1:0]);
        int mn = (mx < my) ? mx : my;
        logic sg = (x[M] ^ y[M]) && (mn != 0);
        return {sg, M'(mn)};
    endfunction

    function automatic logic [Q-1:0] ref_g(input logic [Q-1:0] x, input logic [Q-1:0] y,
                                           input logic s);
        int vx = to_int(x);
        return to_sm((s ? -vx : vx) + to_int(y));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h s=%0d g=%0d fz=%0d%0d act=%h exp=%h",
                     tag, a, b, psum, sel_g, frz0, frz1, act, exp);
        end
    endtask

    task automatic apply(input logic [Q-1:0] ia, input logic [Q-1:0] ib, input logic ip,
                         input logic ig, input logic iz0, input logic iz1);
        logic [Q-1:0] e_llr;
        logic e0, e1;
        @(negedge clk);
        a = ia; b = ib; psum = ip; sel_g = ig; frz0 = iz0; frz1 = iz1;
        e_llr = ig ? ref_g(ia, ib, ip) : ref_f(ia, ib);
        e0 = iz0 ? 1'b0 : ref_f(ia, ib)[M];
        e1 = iz1 ? 1'b0 : ref_g(ia, ib, e0)[M];
        #5;
        if (ig) chk("R2 R3 R4 R5 llr_g", int'(llr_out), int'(e_llr));
        else if (ip) chk("R1 R4 R5 R8 llr_f", int'(llr_out), int'(e_llr));
        else chk("R1 R4 R5 llr_f", int'(llr_out), int'(e_llr));
        chk("R6 bit0", int'(bit0), int'(e0));
        chk("R7 bit1", int'(bit1), int'(e1));
    endtask

    initial begin
        #(LIMIT * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        a = '0; b = '0; psum = 0; sel_g = 0; frz0 = 0; frz1 = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // directed corners: saturation, negative zero, equal magnitudes
        apply(5'h0F, 5'h0F, 1'b0, 1'b1, 1'b0, 1'b0); // R3 clamp positive
        apply(5'h1F, 5'h0F, 1'b1, 1'b1, 1'b0, 1'b0); // R3 via psum inversion
        apply(5'h07, 5'h17, 1'b0, 1'b1, 1'b0, 1'b0); // R4 cancel to zero
        apply(5'h10, 5'h03, 1'b0, 1'b0, 1'b0, 1'b0); // R4 f with -0 input
        apply(5'h19, 5'h02, 1'b0, 1'b0, 1'b1, 1'b0); // R6 frozen forces bit0
        // exhaustive sweep
        for (int ia = 0; ia < (1 << Q); ia++)
            for (int ib = 0; ib < (1 << Q); ib++)
                for (int k = 0; k < 16; k++)
                    apply(Q'(ia), Q'(ib), k[0], k[1], k[2], k[3]);
        // seeded random pass
        for (int r = 0; r < 2000; r++) begin
            logic [31:0] w = $urandom;
            apply(w[Q-1:0], w[2*Q-1:Q], w[10], w[11], w[12], w[13]);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule